// File: doc/BRIEF.md
# Status-Coded I2C Bus Master

This block is an I2C bus master that software drives one bus event at a time. Each event can be a START, a repeated START, an address byte, a data byte sent, a data byte received, or a STOP. After each event the controller stops and publishes an 8-bit status code. It raises an interrupt flag and keeps SCL low until software clears the flag. Software decides the next step from the code. It writes the data register and sets or clears control bits through two write-one registers: one sets bits and the other clears them.

The register port is word-indexed. Index n corresponds to byte offset 4·n. Index 0 is the control-set register and reads back the control bits. Index 1 is the read-only status code. Index 2 is the byte data register. Index 3 is a stored own-address byte. Indices 4 and 5 hold the SCL high and low periods in core clocks. Index 6 is the control-clear register, which reads as zero.

The bus pins are open-drain. Two outputs request a pull-down on SCL and on SDA, and one input returns the resolved SDA level.

Top module: `i2c_stat_master`

## Requirements
- R1: After reset the status reads 0xF8, the control bits read 0, the interrupt output is low and neither line is pulled down.
- R2: The control bits are AA at bit 2, SI at bit 3, STO at bit 4, STA at bit 5 and EN at bit 6. Writing a 1 to a bit at index 0 sets it. Writing a 1 to a bit at index 6 clears it. Index 0 reads back the current control bits.
- R3: With EN set and SI clear, setting STA while idle produces a START (SDA falls while SCL is high). The controller then sets SI with status 0x08. The interrupt output equals SI AND EN.
- R4: An address byte sent with bit 0 clear returns 0x18 on ACK and 0x20 on NACK. An address byte sent with bit 0 set returns 0x40 on ACK and 0x48 on NACK.
- R5: A data byte is sent MSB first from the data register. It returns 0x28 on ACK and 0x30 on NACK.
- R6: When receiving, the controller drives ACK in the ninth bit when AA is set, giving 0x50. When AA is clear it leaves SDA high, giving 0x58. In both cases the data register then holds the received byte.
- R7: Setting STA and then clearing SI while the bus is owned produces a repeated START with status 0x10.
- R8: Setting STO and then clearing SI produces a STOP (SDA rises while SCL is high). Afterwards STO clears itself, the status returns to 0xF8 and SI stays clear.
- R9: While SI is set after a byte or START, SCL stays pulled low and the status code does not change.
- R10: If the controller releases SDA for a 1 bit and samples it low, it stops driving both lines and reports 0x38 with SI set. Clearing STA, STO and SI then returns it to 0xF8 without emitting any bus condition.
- R11: Within a byte, SCL stays high for exactly the high-period count and low for exactly the low-period count, in core clocks.
- R12: Clearing EN returns the status to 0xF8, releases both lines and forces the interrupt output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (3) | Register word index |
| reg_wdata | input | BUS_W (8) | Register write data |
| reg_rdata | output | BUS_W (8) | Register read data for reg_addr |
| irq_o | output | 1 | Interrupt, SI AND EN |
| scl_low_o | output | 1 | Pull SCL low when 1 |
| sda_low_o | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Resolved SDA level |

## Verification
Arbitration loss is the hardest state to reach, because no normal slave ever pulls SDA low while the master sends a 1. The bench adds a third open-drain driver that jams SDA low after the START has been acknowledged. It then sends an address whose MSB is 1, so the loss happens on the first bit. The bench also confirms that releasing the jam and clearing the flags produces no new START. Receive-side NACK handling is exercised with a behavioural slave that shifts out a known byte sequence and stops driving once it sees a NACK. Without that, the following repeated START could not take place.

// File: rtl/i2c_sm_pkg.sv
package i2c_sm_pkg;

    localparam int BIT_AA  = 2;
    localparam int BIT_SI  = 3;
    localparam int BIT_STO = 4;
    localparam int BIT_STA = 5;
    localparam int BIT_EN  = 6;

    localparam logic [7:0] CODE_START  = 8'h08;
    localparam logic [7:0] CODE_RSTART = 8'h10;
    localparam logic [7:0] CODE_AW_ACK = 8'h18;
    localparam logic [7:0] CODE_AW_NAK = 8'h20;
    localparam logic [7:0] CODE_DW_ACK = 8'h28;
    localparam logic [7:0] CODE_DW_NAK = 8'h30;
    localparam logic [7:0] CODE_LOST   = 8'h38;
    localparam logic [7:0] CODE_AR_ACK = 8'h40;
    localparam logic [7:0] CODE_AR_NAK = 8'h48;
    localparam logic [7:0] CODE_DR_ACK = 8'h50;
    localparam logic [7:0] CODE_DR_NAK = 8'h58;
    localparam logic [7:0] CODE_IDLE   = 8'hF8;

    localparam int IDX_SET  = 0;
    localparam int IDX_STAT = 1;
    localparam int IDX_DATA = 2;
    localparam int IDX_OWN  = 3;
    localparam int IDX_HI   = 4;
    localparam int IDX_LO   = 5;
    localparam int IDX_CLR  = 6;

    typedef struct packed {
        logic en;
        logic sta;
        logic sto;
        logic si;
        logic aa;
    } ctrl_t;

    typedef enum logic [3:0] {
        PH_IDLE, PH_START, PH_LOW, PH_HIGH, PH_HOLD,
        PH_RS_LOW, PH_RS_HIGH, PH_SP_LOW, PH_SP_HIGH, PH_SP_REL, PH_LOST
    } phase_e;

endpackage

// File: rtl/i2c_sm_regs.sv
module i2c_sm_regs
    import i2c_sm_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int AW     = 3,
    parameter int HI_RST = 5,
    parameter int LO_RST = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic [7:0]       status,
    input  logic             hw_si_set,
    input  logic             hw_sto_clr,
    input  logic             rx_load,
    input  logic [7:0]       rx_byte,
    output ctrl_t            ctrl,
    output logic [7:0]       data,
    output logic [BUS_W-1:0] hi_cnt,
    output logic [BUS_W-1:0] lo_cnt
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [7:0]       data;
        logic [7:0]       own;
        logic [BUS_W-1:0] hi;
        logic [BUS_W-1:0] lo;
    } regs_t;

    regs_t r_d, r_q;
    ctrl_t wbits;

    always_comb begin
        wbits = '{en: wdata[BIT_EN], sta: wdata[BIT_STA], sto: wdata[BIT_STO],
                  si: wdata[BIT_SI], aa: wdata[BIT_AA]};
        r_d = r_q;
        if (wr_en) begin
            case (int'(addr))
                IDX_SET:  r_d.ctrl = ctrl_t'(r_q.ctrl | wbits);
                IDX_CLR:  r_d.ctrl = ctrl_t'(r_q.ctrl & ~wbits);
                IDX_DATA: r_d.data = wdata[7:0];
                IDX_OWN:  r_d.own  = wdata[7:0];
                IDX_HI:   r_d.hi   = wdata;
                IDX_LO:   r_d.lo   = wdata;
                default:  ;
            endcase
        end
        if (rx_load)    r_d.data    = rx_byte;
        if (hw_si_set)  r_d.ctrl.si = 1'b1;
        if (hw_sto_clr) r_d.ctrl.sto = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctrl <= '0;
            r_q.data <= '0;
            r_q.own  <= '0;
            r_q.hi   <= BUS_W'(HI_RST);
            r_q.lo   <= BUS_W'(LO_RST);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (int'(addr))
            IDX_SET: begin
                rdata[BIT_EN]  = r_q.ctrl.en;
                rdata[BIT_STA] = r_q.ctrl.sta;
                rdata[BIT_STO] = r_q.ctrl.sto;
                rdata[BIT_SI]  = r_q.ctrl.si;
                rdata[BIT_AA]  = r_q.ctrl.aa;
            end
            IDX_STAT: rdata[7:0] = status;
            IDX_DATA: rdata[7:0] = r_q.data;
            IDX_OWN:  rdata[7:0] = r_q.own;
            IDX_HI:   rdata      = r_q.hi;
            IDX_LO:   rdata      = r_q.lo;
            default:  rdata      = '0;
        endcase
    end

    assign ctrl   = r_q.ctrl;
    assign data   = r_q.data;
    assign hi_cnt = r_q.hi;
    assign lo_cnt = r_q.lo;

endmodule

// File: rtl/i2c_sm_core.sv
module i2c_sm_core
    import i2c_sm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic [7:0]       tx_byte,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] lo_cnt,
    input  logic             sda_i,
    output logic [7:0]       status,
    output logic             hw_si_set,
    output logic             hw_sto_clr,
    output logic             rx_load,
    output logic [7:0]       rx_byte,
    output logic             scl_low,
    output logic             sda_low
);

    localparam int BITS = 8;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [3:0]       bitn;
        logic [7:0]       sh;
        logic             tx;
        logic             addr;
        logic             rep;
        logic [7:0]       code;
    } core_t;

    localparam core_t CORE_RST = '{ph: PH_IDLE, cnt: '0, bitn: '0, sh: '0,
                                   tx: 1'b0, addr: 1'b0, rep: 1'b0, code: CODE_IDLE};

    core_t s_d, s_q;
    logic [CNT_W-1:0] hi_ld, lo_ld;
    logic done, ack, last_bit;

    assign hi_ld    = hi_cnt - 1'b1;
    assign lo_ld    = lo_cnt - 1'b1;
    assign done     = (s_q.cnt == '0);
    assign ack      = !sda_i;
    assign last_bit = (s_q.bitn == 4'(BITS));

    always_comb begin
        s_d        = s_q;
        hw_si_set  = 1'b0;
        hw_sto_clr = 1'b0;
        rx_load    = 1'b0;
        rx_byte    = s_q.sh;
        if (!done) s_d.cnt = s_q.cnt - 1'b1;
        case (s_q.ph)
            PH_IDLE: begin
                s_d.code = CODE_IDLE;
                if (ctrl.sta && !ctrl.si) begin
                    s_d.ph  = PH_START;
                    s_d.cnt = hi_ld;
                    s_d.rep = 1'b0;
                end
            end
            PH_START: if (done) begin
                s_d.ph    = PH_HOLD;
                s_d.code  = s_q.rep ? CODE_RSTART : CODE_START;
                hw_si_set = 1'b1;
            end
            PH_HOLD: if (!ctrl.si) begin
                s_d.cnt = lo_ld;
                if (ctrl.sto) begin
                    s_d.ph = PH_SP_LOW;
                end else if (ctrl.sta) begin
                    s_d.ph = PH_RS_LOW;
                end else begin
                    s_d.ph   = PH_LOW;
                    s_d.bitn = '0;
                    s_d.sh   = tx_byte;
                    case (s_q.code)
                        CODE_START, CODE_RSTART: begin s_d.addr = 1'b1; s_d.tx = 1'b1; end
                        CODE_AW_ACK, CODE_AW_NAK,
                        CODE_DW_ACK, CODE_DW_NAK: begin s_d.addr = 1'b0; s_d.tx = 1'b1; end
                        default:                  begin s_d.addr = 1'b0; s_d.tx = 1'b0; end
                    endcase
                end
            end
            PH_LOW: if (done) begin
                s_d.ph  = PH_HIGH;
                s_d.cnt = hi_ld;
            end
            PH_HIGH: if (done) begin
                if (!last_bit) begin
                    if (s_q.tx && s_q.sh[7] && !sda_i) begin
                        s_d.ph    = PH_LOST;
                        s_d.code  = CODE_LOST;
                        hw_si_set = 1'b1;
                    end else begin
                        s_d.sh   = {s_q.sh[6:0], sda_i};
                        s_d.bitn = s_q.bitn + 1'b1;
                        s_d.ph   = PH_LOW;
                        s_d.cnt  = lo_ld;
                    end
                end else begin
                    s_d.ph    = PH_HOLD;
                    hw_si_set = 1'b1;
                    if (s_q.addr) begin
                        if (s_q.sh[0]) s_d.code = ack ? CODE_AR_ACK : CODE_AR_NAK;
                        else           s_d.code = ack ? CODE_AW_ACK : CODE_AW_NAK;
                    end else if (s_q.tx) begin
                        s_d.code = ack ? CODE_DW_ACK : CODE_DW_NAK;
                    end else begin
                        s_d.code = ack ? CODE_DR_ACK : CODE_DR_NAK;
                        rx_load  = 1'b1;
                    end
                end
            end
            PH_RS_LOW:  if (done) begin s_d.ph = PH_RS_HIGH; s_d.cnt = hi_ld; end
            PH_RS_HIGH: if (done) begin s_d.ph = PH_START; s_d.cnt = hi_ld; s_d.rep = 1'b1; end
            PH_SP_LOW:  if (done) begin s_d.ph = PH_SP_HIGH; s_d.cnt = hi_ld; end
            PH_SP_HIGH: if (done) begin s_d.ph = PH_SP_REL; s_d.cnt = hi_ld; end
            PH_SP_REL: if (done) begin
                s_d.ph     = PH_IDLE;
                s_d.code   = CODE_IDLE;
                hw_sto_clr = 1'b1;
            end
            PH_LOST: if (!ctrl.si) begin
                s_d.ph   = PH_IDLE;
                s_d.code = CODE_IDLE;
            end
            default: s_d = CORE_RST;
        endcase
        if (!ctrl.en) begin
            s_d        = CORE_RST;
            hw_si_set  = 1'b0;
            hw_sto_clr = 1'b0;
            rx_load    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= CORE_RST;
        else        s_q <= s_d;
    end

    always_comb begin
        scl_low = 1'b0;
        sda_low = 1'b0;
        case (s_q.ph)
            PH_START:  sda_low = 1'b1;
            PH_HOLD:   begin scl_low = 1'b1; sda_low = 1'b1; end
            PH_LOW, PH_HIGH: begin
                scl_low = (s_q.ph == PH_LOW);
                sda_low = last_bit ? (!s_q.tx && ctrl.aa) : (s_q.tx && !s_q.sh[7]);
            end
            PH_RS_LOW: scl_low = 1'b1;
            PH_SP_LOW: begin scl_low = 1'b1; sda_low = 1'b1; end
            PH_SP_HIGH: sda_low = 1'b1;
            default: ;
        endcase
    end

    assign status = s_q.code;

endmodule

// File: rtl/i2c_stat_master.sv
module i2c_stat_master
    import i2c_sm_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int AW     = 3,
    parameter int HI_RST = 5,
    parameter int LO_RST = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata,
    output logic             irq_o,
    output logic             scl_low_o,
    output logic             sda_low_o,
    input  logic             sda_i
);

    ctrl_t            ctrl_w;
    logic [7:0]       data_w;
    logic [7:0]       status_w;
    logic [7:0]       rx_byte_w;
    logic [BUS_W-1:0] hi_w, lo_w;
    logic             si_set_w, sto_clr_w, rx_load_w;
    logic             en_w;

    i2c_sm_regs #(.BUS_W(BUS_W), .AW(AW), .HI_RST(HI_RST), .LO_RST(LO_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .status(status_w),
        .hw_si_set(si_set_w), .hw_sto_clr(sto_clr_w), .rx_load(rx_load_w),
        .rx_byte(rx_byte_w), .ctrl(ctrl_w), .data(data_w),
        .hi_cnt(hi_w), .lo_cnt(lo_w)
    );

    i2c_sm_core #(.CNT_W(BUS_W)) u_core (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl_w), .tx_byte(data_w),
        .hi_cnt(hi_w), .lo_cnt(lo_w), .sda_i(sda_i), .status(status_w),
        .hw_si_set(si_set_w), .hw_sto_clr(sto_clr_w), .rx_load(rx_load_w),
        .rx_byte(rx_byte_w), .scl_low(scl_low_o), .sda_low(sda_low_o)
    );

    assign en_w  = ctrl_w.en;
    assign irq_o = ctrl_w.si & ctrl_w.en;

endmodule

// File: rtl/i2c_stat_master_chk.sv
module i2c_stat_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       scl_low,
    input logic       sda_low,
    input logic [7:0] status,
    input logic       en
);

    // R9
    hold_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && status != 8'h38 && status != 8'hF8) |-> scl_low);

    // R9
    hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(irq)) |-> $stable(status));

    // R10
    arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 8'h38) |-> (!scl_low && !sda_low));

    // R12
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (status == 8'hF8 && !scl_low && !sda_low));

endmodule

bind i2c_stat_master i2c_stat_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq_o), .scl_low(scl_low_o),
    .sda_low(sda_low_o), .status(status_w), .en(en_w)
);

// File: tb/sim_i2c_stat_master.sv
`timescale 1ns/100ps
module sim_i2c_stat_master;

    localparam logic [2:0] A_SET = 3'd0, A_STAT = 3'd1, A_DATA = 3'd2,
                           A_HI = 3'd4, A_LO = 3'd5, A_CLR = 3'd6;
    localparam logic [7:0] C_AA = 8'h04, C_SI = 8'h08, C_STO = 8'h10,
                           C_STA = 8'h20, C_EN = 8'h40;
    localparam logic [6:0] SADDR = 7'h50;
    localparam int HI = 3, LO = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [2:0] reg_addr = A_STAT;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic irq_o, scl_low_o, sda_low_o;
    logic s_low = 1'b0, jam = 1'b0, nack_data = 1'b0;
    wire scl = !scl_low_o;
    wire sda = !(sda_low_o || s_low || jam);

    int total = 0, bad = 0;
    logic [7:0] exp_q[$];
    string      req_q[$];
    logic [7:0] got_q[$];
    int starts = 0;

    always #2.5 clk = !clk;

    i2c_stat_master u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o),
        .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .sda_i(sda)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: compares each new status code against the scoreboard
    logic irq_seen = 1'b0;
    always @(negedge clk) begin
        if (rst_n && irq_o && !irq_seen) begin
            if (exp_q.size() == 0) chk(1'b0, "R9", "unexpected event", reg_rdata, 0);
            else begin
                logic [7:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                chk(reg_rdata == e, r, "status code", reg_rdata, e);
            end
        end
        irq_seen = irq_o;
    end

    // SCL period measurement
    int run = 0, last_hi = 0, last_lo = 0;
    logic pscl_m = 1'b1;
    always @(negedge clk) begin
        if (scl == pscl_m) run++;
        else begin
            if (pscl_m) last_hi = run; else last_lo = run;
            run = 1;
        end
        pscl_m = scl;
    end

    // behavioural slave at address SADDR
    logic pscl = 1'b1, psda = 1'b1;
    int bitn = 0;
    logic addr_ph = 1'b0, reading = 1'b0, wr_ok = 1'b0;
    logic [7:0] shreg = '0, tx_byte = '0;
    always @(negedge clk) begin
        if (pscl && scl && psda && !sda) begin
            starts++; bitn = 0; addr_ph = 1'b1; reading = 1'b0; s_low = 1'b0;
        end else if (!pscl && scl) begin
            if (bitn < 8) begin
                shreg = {shreg[6:0], sda};
                bitn++;
            end else begin
                bitn = 0;
                if (addr_ph) begin
                    addr_ph = 1'b0;
                    reading = shreg[0] && (shreg[7:1] == SADDR);
                    wr_ok   = !shreg[0] && (shreg[7:1] == SADDR);
                    tx_byte = 8'h5A;
                end else if (!reading) begin
                    got_q.push_back(shreg);
                end else if (sda) begin
                    reading = 1'b0;
                end else begin
                    tx_byte = tx_byte + 8'h11;
                end
            end
        end else if (pscl && !scl) begin
            if (bitn == 8)
                s_low = reading ? 1'b0 :
                        (addr_ph ? (shreg[7:1] == SADDR) : (wr_ok && !nack_data));
            else if (reading && !addr_ph) s_low = !tx_byte[7-bitn];
            else s_low = 1'b0;
        end
        pscl = scl;
        psda = sda;
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = A_STAT;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = A_STAT;
    endtask

    // driver: push expected code, then wait for the event
    task automatic expect_code(input logic [7:0] code, input string req);
        bit seen = 1'b0;
        exp_q.push_back(code);
        req_q.push_back(req);
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            if (irq_o) seen = 1'b1;
        end
        if (!seen) chk(1'b0, req, "no event", 0, code);
    endtask

    task automatic wait_idle(input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            if (reg_rdata == 8'hF8) seen = 1'b1;
        end
        chk(seen, req, "return to idle", reg_rdata, 8'hF8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int st0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_STAT, v); chk(v == 8'hF8, "R1", "reset status", v, 8'hF8);
        rd(A_SET, v);  chk(v == 8'h00, "R1", "reset control", v, 0);
        chk(!irq_o && scl && sda, "R1", "reset irq/lines", {irq_o, scl, sda}, 3'b011);

        wr(A_HI, HI[7:0]); wr(A_LO, LO[7:0]);
        // R2 set/clear control bits
        wr(A_SET, C_EN | C_AA);
        rd(A_SET, v); chk(v == 8'h44, "R2", "set EN|AA", v, 8'h44);
        wr(A_CLR, C_AA);
        rd(A_SET, v); chk(v == 8'h40, "R2", "clear AA", v, 8'h40);
        rd(A_CLR, v); chk(v == 8'h00, "R2", "clear reg reads 0", v, 0);
        chk(!irq_o, "R3", "irq low while SI clear", irq_o, 0);

        // write transfer
        st0 = starts;
        wr(A_SET, C_STA);
        expect_code(8'h08, "R3");
        chk(starts == st0 + 1, "R3", "START on bus", starts, st0 + 1);
        rd(A_SET, v); chk(v == 8'h68, "R3", "SI set with EN|STA", v, 8'h68);
        repeat (20) @(negedge clk);
        rd(A_STAT, v); chk(v == 8'h08 && !scl, "R9", "held with SCL low", {v, scl}, 9'h010);
        wr(A_DATA, {SADDR, 1'b0});
        wr(A_CLR, C_STA | C_SI);
        expect_code(8'h18, "R4");
        wr(A_DATA, 8'h3C);
        wr(A_CLR, C_SI);
        expect_code(8'h28, "R5");
        chk(last_hi == HI, "R11", "SCL high period", last_hi, HI);
        chk(last_lo == LO, "R11", "SCL low period", last_lo, LO);
        chk(got_q.size() > 0 && got_q[0] == 8'h3C, "R5", "slave byte",
            got_q.size() > 0 ? got_q[0] : -1, 8'h3C);
        nack_data = 1'b1;
        wr(A_DATA, 8'h99);
        wr(A_CLR, C_SI);
        expect_code(8'h30, "R5");
        nack_data = 1'b0;
        wr(A_SET, C_STO);
        wr(A_CLR, C_SI);
        wait_idle("R8");
        rd(A_SET, v); chk(v == 8'h40, "R8", "STO and SI clear after STOP", v, 8'h40);
        chk(scl && sda && !irq_o, "R8", "bus released", {scl, sda, irq_o}, 3'b110);

        // address NACK on write
        wr(A_SET, C_STA);
        expect_code(8'h08, "R3");
        wr(A_DATA, 8'h52);
        wr(A_CLR, C_STA | C_SI);
        expect_code(8'h20, "R4");
        wr(A_SET, C_STO);
        wr(A_CLR, C_SI);
        wait_idle("R8");

        // read transfer, then repeated start
        wr(A_SET, C_STA);
        expect_code(8'h08, "R3");
        wr(A_DATA, {SADDR, 1'b1});
        wr(A_CLR, C_STA | C_SI);
        expect_code(8'h40, "R4");
        wr(A_SET, C_AA);
        wr(A_CLR, C_SI);
        expect_code(8'h50, "R6");
        rd(A_DATA, v); chk(v == 8'h5A, "R6", "first rx byte", v, 8'h5A);
        wr(A_CLR, C_AA | C_SI);
        expect_code(8'h58, "R6");
        rd(A_DATA, v); chk(v == 8'h6B, "R6", "last rx byte", v, 8'h6B);
        st0 = starts;
        wr(A_SET, C_STA);
        wr(A_CLR, C_SI);
        expect_code(8'h10, "R7");
        chk(starts == st0 + 1, "R7", "repeated START on bus", starts, st0 + 1);
        wr(A_DATA, 8'hA3);
        wr(A_CLR, C_STA | C_SI);
        expect_code(8'h48, "R4");
        wr(A_SET, C_STO);
        wr(A_CLR, C_SI);
        wait_idle("R8");

        // arbitration loss
        wr(A_SET, C_STA);
        expect_code(8'h08, "R3");
        wr(A_DATA, {SADDR, 1'b0});
        jam = 1'b1;
        wr(A_CLR, C_STA | C_SI);
        expect_code(8'h38, "R10");
        jam = 1'b0;
        repeat (2) @(negedge clk);
        chk(scl && sda, "R10", "lines released", {scl, sda}, 2'b11);
        st0 = starts;
        wr(A_CLR, C_STA | C_STO | C_SI);
        wait_idle("R10");
        repeat (30) @(negedge clk);
        chk(starts == st0 && scl && sda, "R10", "no condition after release",
            starts, st0);

        // disable mid-transfer
        wr(A_SET, C_STA);
        expect_code(8'h08, "R3");
        wr(A_CLR, C_EN);
        chk(!irq_o, "R12", "irq forced low", irq_o, 0);
        repeat (2) @(negedge clk);
        rd(A_STAT, v); chk(v == 8'hF8, "R12", "status idle", v, 8'hF8);
        chk(scl && sda, "R12", "lines released", {scl, sda}, 2'b11);
        wr(A_CLR, C_STA | C_SI);
        chk(exp_q.size() == 0, "R9", "all events seen", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule